// File: doc/BRIEF.md
# Modulo 2^n+1 Adder

This block adds two operands and reduces the sum modulo 2^n+1 in a single combinational pass. Each operand may take any value from 0 up to and including 2^n, so both inputs and the result carry one bit above the n-bit core. Such residues appear in number-theoretic transforms, residue-number arithmetic and some hashing and cipher datapaths. Those users need a modular sum at roughly the cost and delay of an ordinary fast adder.

Internally, a carry-free biasing row turns the operands into a pair whose sum is offset by 2^n-1. A parallel-prefix carry network then classifies the carry out of the low n bits as kill, propagate or generate. That class, together with the top bias bit, decides whether an end-around "+1" is applied. The "+1" goes through a late-carry row whose depth does not depend on n. The result's top bit is derived separately. An operand equal to 2^n is folded into all-ones plus an input carry, and the case where both operands equal 2^n is resolved directly.

Top module: `mod2n1_adder`

## Requirements
- R1: For any operands a_in and b_in in the range 0 to 2^N, sum_out equals (a_in + b_in) mod (2^N+1).
- R2: When a_in + b_in is at most 2^N, sum_out equals a_in + b_in unchanged, including the exact value 2^N.
- R3: When a_in + b_in is 2^N+1 or more, sum_out equals a_in + b_in - 2^N - 1.
- R4: When both operands equal 2^N (bit N set, all lower bits zero), sum_out equals 2^N-1.
- R5: When exactly one operand equals 2^N and the other is v, sum_out equals v-1 for v at least 1 and equals 2^N for v = 0.
- R6: Bit N of sum_out is 1 only when the result is exactly 2^N, so its lower N bits are then all zero.
- R7: The result does not depend on operand order: swapping a_in and b_in leaves sum_out unchanged.
- R8: With a_in equal to zero, sum_out equals b_in.
- R9: For legal operands, sum_out never exceeds 2^N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | N+1 | First operand, legal range 0 to 2^N |
| b_in | input | N+1 | Second operand, legal range 0 to 2^N |
| sum_out | output | N+1 | Sum of the operands modulo 2^N+1 |

## Verification
The bench sweeps every legal operand pair for two small widths. It concentrates on the seams of the end-around correction, listed here with how a faulty design would fail at each:
- A sum of exactly 2^N needs the propagate class to raise the top bit. A wrong class decode returns zero or sets stray low bits instead.
- A sum of exactly 2^N+1 must wrap to zero. An increment control with the wrong polarity returns one there.
- Operands equal to 2^N exercise the input rewrite. A missing input carry or a missing override for two top-valued operands gives results off by one, or results that overflow past 2^N.

Both orders of every pair are applied, so an asymmetric rewrite shows up as an order-dependent result.

// File: rtl/mod2n1_pkg.sv
package mod2n1_pkg;

    typedef enum logic [1:0] {
        CC_KILL = 2'd0,
        CC_PROP = 2'd1,
        CC_GEN  = 2'd2
    } carry_cls_e;

    function automatic carry_cls_e classify(input logic gen, input logic prop);
        if (gen)
            return CC_GEN;
        else if (prop)
            return CC_PROP;
        else
            return CC_KILL;
    endfunction

endpackage

// File: rtl/mod2n1_rewrite.sv
module mod2n1_rewrite #(
    parameter int N = 8
) (
    input  logic [N:0]   a_in,
    input  logic [N:0]   b_in,
    output logic [N-1:0] a_low,
    output logic [N-1:0] b_low,
    output logic         cin,
    output logic         both_top
);
    logic a_top;
    logic b_top;

    always_comb begin
        a_top    = a_in[N];
        b_top    = b_in[N];
        // an operand of 2^N becomes (2^N-1) plus one carried in at bit 0
        a_low    = a_top ? {N{1'b1}} : a_in[N-1:0];
        b_low    = b_top ? {N{1'b1}} : b_in[N-1:0];
        cin      = a_top ^ b_top;
        both_top = a_top & b_top;
    end
endmodule

// File: rtl/mod2n1_bias_row.sv
module mod2n1_bias_row #(
    parameter int N = 8
) (
    input  logic [N-1:0] a_low,
    input  logic [N-1:0] b_low,
    input  logic         cin,
    output logic [N:0]   x_vec,
    output logic [N-1:0] y_vec
);
    // per bit: a+b+1 = 2*(a|b) + ~(a^b); summed over bits adds 2^N-1
    assign x_vec[0] = cin;

    for (genvar i = 0; i < N; i++) begin : g_cell
        assign y_vec[i]   = ~(a_low[i] ^ b_low[i]);
        assign x_vec[i+1] = a_low[i] | b_low[i];
    end
endmodule

// File: rtl/mod2n1_sklansky.sv
module mod2n1_sklansky #(
    parameter int N = 8
) (
    input  logic [N-1:0] x_low,
    input  logic [N-1:0] y_low,
    output logic [N-1:0] half_sum,
    output logic [N-1:0] grp_gen,
    output logic [N-1:0] grp_prop
);
    localparam int LEVELS = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0] gen_v;
    logic [N-1:0] prop_v;

    always_comb begin
        half_sum = x_low ^ y_low;
        gen_v    = x_low & y_low;
        prop_v   = x_low ^ y_low;
        for (int lvl = 0; lvl < LEVELS; lvl++) begin
            for (int i = 0; i < N; i++) begin
                if (((i >> lvl) & 1) == 1) begin
                    // partner is the top bit of the lower block at this level
                    int j;
                    j = ((i >> lvl) << lvl) - 1;
                    gen_v[i]  = gen_v[i] | (prop_v[i] & gen_v[j]);
                    prop_v[i] = prop_v[i] & prop_v[j];
                end
            end
        end
        grp_gen  = gen_v;
        grp_prop = prop_v;
    end
endmodule

// File: rtl/mod2n1_adder.sv
module mod2n1_adder
    import mod2n1_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N:0] a_in,
    input  logic [N:0] b_in,
    output logic [N:0] sum_out
);
    logic [N-1:0] a_low;
    logic [N-1:0] b_low;
    logic         cin;
    logic         both_top;
    logic [N:0]   x_vec;
    logic [N-1:0] y_vec;
    logic [N-1:0] half_sum;
    logic [N-1:0] grp_gen;
    logic [N-1:0] grp_prop;

    carry_cls_e   top_cls;
    logic         inc_en;
    logic [N-1:0] late_carry;
    logic [N:0]   core_sum;

    mod2n1_rewrite #(.N(N)) u_rewrite (
        .a_in     (a_in),
        .b_in     (b_in),
        .a_low    (a_low),
        .b_low    (b_low),
        .cin      (cin),
        .both_top (both_top)
    );

    mod2n1_bias_row #(.N(N)) u_bias (
        .a_low (a_low),
        .b_low (b_low),
        .cin   (cin),
        .x_vec (x_vec),
        .y_vec (y_vec)
    );

    mod2n1_sklansky #(.N(N)) u_prefix (
        .x_low    (x_vec[N-1:0]),
        .y_low    (y_vec),
        .half_sum (half_sum),
        .grp_gen  (grp_gen),
        .grp_prop (grp_prop)
    );

    always_comb begin
        top_cls = classify(grp_gen[N-1], grp_prop[N-1]);
        // the +1 is dropped only when the biased sum reaches 2^(N+1)
        inc_en  = ~(x_vec[N] & (top_cls == CC_GEN));
        late_carry[0] = inc_en;
        for (int i = 1; i < N; i++)
            late_carry[i] = grp_gen[i-1] | (grp_prop[i-1] & inc_en);
        core_sum[N-1:0] = half_sum ^ late_carry;
        core_sum[N]     = x_vec[N] & (top_cls == CC_PROP);
        sum_out = both_top ? {1'b0, {N{1'b1}}} : core_sum;
    end
endmodule

// File: rtl/mod2n1_adder_chk.sv
module mod2n1_adder_chk #(
    parameter int N = 8
) (
    input logic [N:0] a_in,
    input logic [N:0] b_in,
    input logic [N:0] sum_out
);
    localparam logic [N+1:0] TOPV = (N+2)'(1) << N;

    logic [N+1:0] a_w;
    logic [N+1:0] b_w;
    logic [N+1:0] s_w;
    logic         legal;

    always_comb begin
        a_w   = {1'b0, a_in};
        b_w   = {1'b0, b_in};
        s_w   = {1'b0, sum_out};
        legal = (a_w <= TOPV) && (b_w <= TOPV);
        if (legal) begin
            assert_in_range_R9: assert (s_w <= TOPV);
            assert_top_clean_R6: assert (!sum_out[N] || (sum_out[N-1:0] == '0));
            if (a_in == '0)
                assert_zero_identity_R8: assert (sum_out == b_in);
            if ((a_w == TOPV) && (b_w == TOPV))
                assert_both_top_R4: assert (s_w == TOPV - 1);
            if ((a_w + b_w) <= TOPV)
                assert_no_wrap_R2: assert (s_w == a_w + b_w);
        end
    end
endmodule

bind mod2n1_adder mod2n1_adder_chk #(.N(N)) u_chk (
    .a_in    (a_in),
    .b_in    (b_in),
    .sum_out (sum_out)
);

// File: tb/mod2n1_adder_test.sv
module mod2n1_adder_test;
    localparam int NB = 6;
    localparam int NS = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [NB:0] a_b, b_b, s_b;
    logic [NS:0] a_s, b_s, s_s;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    mod2n1_adder #(.N(NB)) uut (.a_in(a_b), .b_in(b_b), .sum_out(s_b));
    mod2n1_adder #(.N(NS)) uut_small (.a_in(a_s), .b_in(b_s), .sum_out(s_s));

    function automatic string tag_of(int a, int b, int n);
        int top = 1 << n;
        if (a == top && b == top) return "R4";
        if (a == top || b == top) return "R5";
        if (a == 0) return "R8";
        if (a + b <= top) return "R2";
        return "R3";
    endfunction

    task automatic check(string req, int act, int exp, int a, int b);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s R1 a=%0d b=%0d actual=%0d expected=%0d", req, a, b, act, exp);
        end
    endtask

    task automatic sweep_big();
        int top = 1 << NB;
        for (int a = 0; a <= top; a++) begin
            for (int b = 0; b <= top; b++) begin
                @(posedge clk);
                a_b = (NB+1)'(a);
                b_b = (NB+1)'(b);
                @(negedge clk);
                check(tag_of(a, b, NB), int'(s_b), (a + b) % (top + 1), a, b);
                // R6 top bit only with zero low bits; R9 range
                check("R6", int'(s_b[NB] && (s_b[NB-1:0] != '0)), 0, a, b);
                check("R9", int'(int'(s_b) > top), 0, a, b);
                // R7 swapped order
                a_b = (NB+1)'(b);
                b_b = (NB+1)'(a);
                #1;
                check("R7", int'(s_b), (a + b) % (top + 1), b, a);
            end
        end
    endtask

    task automatic sweep_small();
        int top = 1 << NS;
        for (int a = 0; a <= top; a++) begin
            for (int b = 0; b <= top; b++) begin
                @(posedge clk);
                a_s = (NS+1)'(a);
                b_s = (NS+1)'(b);
                @(negedge clk);
                check(tag_of(a, b, NS), int'(s_s), (a + b) % (top + 1), a, b);
            end
        end
    endtask

    initial begin
        a_b = '0; b_b = '0; a_s = '0; b_s = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8", int'(s_b), 0, 0, 0);
        check("R8", int'(s_s), 0, 0, 0);
        rst = 1'b0;
        sweep_small();
        sweep_big();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R1 actual=hung expected=complete");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule